// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit takes one decoded memory instruction with its two register operands and turns it into a single access on a 32-bit data port. It adds the base register to a signed 16-bit displacement to form a byte address. For stores it builds byte-lane enables and shifts the store value into the addressed lanes. For loads it picks the returned byte or halfword from the correct lanes and extends it to 32 bits, either with zeros or with its sign bit. Lane order is big-endian: the byte at address offset 0 sits in bits 31:24 of the bus word.

Stores carry their displacement in two separate instruction fields, and the unit puts them back together. A halfword at an odd address, or a word at an address that is not a multiple of four, raises a one-cycle fault and produces no bus request. Each accepted access holds its request until the port signals ready. Load results come back on a write-back port with a one-cycle valid pulse.

Top module: `lsu_be_align`

## Requirements
- R1: An issued instruction with class `insn[31:30]`=2 and subclass `insn[29:26]` in 0..4 is a load. Subclass 0 is a word, 1 a zero-extended byte, 2 a sign-extended byte, 3 a zero-extended halfword and 4 a sign-extended halfword. It raises `mem_req` on the next cycle with `mem_we`=0 and `mem_addr` = `base_val` + the sign-extended value of `insn[15:0]`.
- R2: An issued instruction with class 3 and subclass 5 (word), 6 (byte) or 7 (halfword) is a store. It raises `mem_req` with `mem_we`=1. Its address is `base_val` plus the sign extension of the 16-bit value {`insn[25:21]`, `insn[10:0]`}.
- R3: `mem_be` bit 3 enables bits 31:24 and bit 0 enables bits 7:0. A byte at address offset k (k = `mem_addr[1:0]`) enables only bit 3-k. A halfword enables 1100 at offset 0 and 0011 at offset 2. A word enables 1111.
- R4: Store write data has the low byte, low halfword or full word of `store_val` in the enabled lanes and zero in every other lane.
- R5: A load result on `wb_data` is the addressed byte (bits 31-8k..24-8k of `mem_rdata`) or the addressed halfword (bits 31:16 at offset 0, bits 15:0 at offset 2), or the full word. Bytes and halfwords are zero-extended or sign-extended according to the subclass.
- R6: A misaligned halfword (odd address) or word (address not a multiple of 4) pulses `fault` for exactly one cycle, the cycle after issue, and raises no `mem_req`.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold their values, and new `issue` pulses are ignored.
- R8: On the clock edge where `mem_req` and `mem_ready` are both high, `mem_req` falls. For a load, `wb_valid` is high for exactly the following cycle, with `wb_data` and `wb_dest` = `insn[25:21]`. A store produces no `wb_valid`.
- R9: An issued instruction outside the load and store encodings produces neither `mem_req` nor `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction valid, sampled while idle |
| insn | input | 32 | Instruction word |
| base_val | input | 32 | Base register value |
| store_val | input | 32 | Store data register value |
| mem_req | output | 1 | Bus request, held until ready |
| mem_we | output | 1 | 1 for store, 0 for load |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-shifted store data |
| mem_ready | input | 1 | Bus accepts/returns the access |
| mem_rdata | input | 32 | Read data, valid with ready on loads |
| fault | output | 1 | Alignment fault pulse |
| wb_valid | output | 1 | Load result valid pulse |
| wb_dest | output | 5 | Destination register index |
| wb_data | output | 32 | Extended load result |

## Verification
The bench aims at the lane boundaries. These are bytes at each of the four offsets, and halfwords at offsets 0 and 2 with the top bit of the data set. Mirrored lanes or missing sign extension show up there as wrong `mem_be` or wrong `wb_data`. Store displacements are drawn with both fields non-zero and negative. A design that read the load displacement field for stores would then produce a wrong address. Misaligned halfwords and words are mixed in with the legal accesses. A design that still issued a request, or stretched the fault, shows a stray `mem_req` or a two-cycle fault. Stray `issue` pulses arrive while an access waits for ready. A design that accepted them would change the held address or enables.

// File: rtl/lsu_be_align.sv
module lsu_be_align (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [31:0] insn,
  input  logic [31:0] base_val,
  input  logic [31:0] store_val,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic        fault,
  output logic        wb_valid,
  output logic [4:0]  wb_dest,
  output logic [31:0] wb_data
);
  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W} size_t;

  wire [1:0] cls = insn[31:30];
  wire [3:0] sub = insn[29:26];
  wire is_ld = (cls == 2'd2) && (sub <= 4'd4);
  wire is_st = (cls == 2'd3) && (sub >= 4'd5) && (sub <= 4'd7);

  size_t sz;
  always_comb begin
    if (is_st) sz = (sub == 4'd5) ? SZ_W : (sub == 4'd6) ? SZ_B : SZ_H;
    else       sz = (sub == 4'd0) ? SZ_W : (sub <= 4'd2) ? SZ_B : SZ_H;
  end

  wire [31:0] disp = is_st ? {{16{insn[25]}}, insn[25:21], insn[10:0]}
                           : {{16{insn[15]}}, insn[15:0]};
  wire [31:0] ea   = base_val + disp;
  wire        mis  = ((sz == SZ_H) && ea[0]) || ((sz == SZ_W) && (ea[1:0] != 2'b00));
  wire        take = issue && !mem_req && (is_ld || is_st);

  logic [3:0]  be_c;
  logic [31:0] wd_c;
  always_comb begin
    case (sz)
      SZ_B:    begin
                 be_c = 4'b1000 >> ea[1:0];
                 wd_c = {24'b0, store_val[7:0]} << {~ea[1:0], 3'b000};
               end
      SZ_H:    begin
                 be_c = ea[1] ? 4'b0011 : 4'b1100;
                 wd_c = ea[1] ? {16'b0, store_val[15:0]} : {store_val[15:0], 16'b0};
               end
      default: begin
                 be_c = 4'b1111;
                 wd_c = store_val;
               end
    endcase
  end

  logic [3:0] sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      sub_q     <= '0;
      wb_dest   <= '0;
      fault     <= 1'b0;
    end else begin
      fault <= take && mis;
      if (take && !mis) begin
        mem_req   <= 1'b1;
        mem_we    <= is_st;
        mem_addr  <= ea;
        mem_be    <= be_c;
        mem_wdata <= is_st ? wd_c : 32'b0;
        sub_q     <= sub;
        wb_dest   <= insn[25:21];
      end else if (mem_req && mem_ready) begin
        mem_req <= 1'b0;
      end
    end
  end

  wire [7:0]  rd_b = 8'(mem_rdata >> {~mem_addr[1:0], 3'b000});
  wire [15:0] rd_h = mem_addr[1] ? mem_rdata[15:0] : mem_rdata[31:16];
  logic [31:0] ld_c;
  always_comb begin
    case (sub_q)
      4'd1:    ld_c = {24'b0, rd_b};
      4'd2:    ld_c = {{24{rd_b[7]}}, rd_b};
      4'd3:    ld_c = {16'b0, rd_h};
      4'd4:    ld_c = {{16{rd_h[15]}}, rd_h};
      default: ld_c = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_data  <= '0;
    end else begin
      wb_valid <= mem_req && mem_ready && !mem_we;
      if (mem_req && mem_ready && !mem_we) wb_data <= ld_c;
    end
  end

  AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 4'b1111 || mem_be == 4'b1100 || mem_be == 4'b0011 || $countones(mem_be) == 1)); // R3
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00)); // R6
  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_req); // R6
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we) && $stable(mem_wdata))); // R7
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> !mem_req); // R8
  AST_WB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mem_req && mem_ready && !mem_we)); // R8
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid); // R8
endmodule

// File: tb/lsu_be_align_test.sv
module lsu_be_align_test;
  logic clk = 0, rst_n = 0, issue = 0, mem_ready = 0;
  logic [31:0] insn = 0, base_val = 0, store_val = 0, mem_rdata = 0;
  logic mem_req, mem_we, fault, wb_valid;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [3:0] mem_be;
  logic [4:0] wb_dest;
  int vectors = 0, errs = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lsu_be_align uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int size_of(input bit st, input int s);
    if (st) return (s == 5) ? 4 : (s == 6) ? 1 : 2;
    return (s == 0) ? 4 : (s <= 2) ? 1 : 2;
  endfunction

  function automatic logic [3:0] exp_be(input int sz, input logic [1:0] o);
    if (sz == 1) return 4'b1000 >> o;
    if (sz == 2) return o[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wd(input int sz, input logic [1:0] o, input logic [31:0] v);
    logic [31:0] r = 0;
    for (int k = 0; k < 4; k++)
      if (exp_be(sz, o)[3-k]) begin
        if (sz == 1) r[31-8*k -: 8] = v[7:0];
        else if (sz == 2) r[31-8*k -: 8] = (k % 2 == 0) ? v[15:8] : v[7:0];
        else r[31-8*k -: 8] = v[31-8*k -: 8];
      end
    return r;
  endfunction

  function automatic logic [31:0] exp_ld(input int s, input logic [1:0] o, input logic [31:0] d);
    logic [7:0] b = d[31-8*o -: 8];
    logic [15:0] h = o[1] ? d[15:0] : d[31:16];
    case (s)
      1: return {24'b0, b};
      2: return {{24{b[7]}}, b};
      3: return {16'b0, h};
      4: return {{16{h[15]}}, h};
      default: return d;
    endcase
  endfunction

  // kind: 0 load, 1 store, 2 other
  task automatic run_op(input int kind, input int s, input logic [31:0] base,
                        input logic [15:0] off, input int waits);
    logic [31:0] a, i, rd;
    int sz;
    logic [4:0] rd_idx = 5'($urandom);
    @(negedge clk);
    if (kind == 0) i = {2'd2, 4'(s), rd_idx, 5'($urandom), off};
    else if (kind == 1) i = {2'd3, 4'(s), off[15:11], 5'($urandom), 5'($urandom), off[10:0]};
    else i = {2'($urandom_range(0,1)), 4'($urandom), 26'($urandom)};
    if (kind == 2 && $urandom_range(0,1) == 1) i = {2'd2, 4'($urandom_range(5,15)), 26'($urandom)};
    a = base + {{16{off[15]}}, off};
    sz = size_of(kind == 1, s);
    issue = 1; insn = i; base_val = base; store_val = $urandom;
    @(posedge clk); @(negedge clk);
    issue = 0;
    if (kind == 2) begin
      chk("R9 req", {31'b0, mem_req}, 0);
      chk("R9 fault", {31'b0, fault}, 0);
      return;
    end
    if ((sz == 2 && a[0]) || (sz == 4 && a[1:0] != 0)) begin
      chk("R6 fault", {31'b0, fault}, 1);
      chk("R6 no req", {31'b0, mem_req}, 0);
      @(posedge clk); @(negedge clk);
      chk("R6 pulse", {31'b0, fault}, 0);
      return;
    end
    chk(kind == 0 ? "R1 req" : "R2 req", {31'b0, mem_req}, 1);
    chk(kind == 0 ? "R1 addr" : "R2 addr", mem_addr, a);
    chk(kind == 0 ? "R1 we" : "R2 we", {31'b0, mem_we}, kind == 1);
    chk("R3 be", {28'b0, mem_be}, {28'b0, exp_be(sz, a[1:0])});
    if (kind == 1) chk("R4 wdata", mem_wdata, exp_wd(sz, a[1:0], store_val));
    for (int w = 0; w < waits; w++) begin
      issue = 1; insn = {2'd2, 4'd0, 26'($urandom)}; base_val = $urandom;
      @(posedge clk); @(negedge clk);
      issue = 0;
      chk("R7 hold req", {31'b0, mem_req}, 1);
      chk("R7 hold addr", mem_addr, a);
      chk("R7 hold be", {28'b0, mem_be}, {28'b0, exp_be(sz, a[1:0])});
    end
    rd = $urandom;
    mem_ready = 1; mem_rdata = rd;
    @(posedge clk); @(negedge clk);
    mem_ready = 0;
    chk("R8 req drop", {31'b0, mem_req}, 0);
    chk("R8 wb_valid", {31'b0, wb_valid}, kind == 0);
    if (kind == 0) begin
      chk("R5 wb_data", wb_data, exp_ld(s, a[1:0], rd));
      chk("R8 wb_dest", {27'b0, wb_dest}, {27'b0, rd_idx});
    end
    @(posedge clk); @(negedge clk);
    chk("R8 wb pulse", {31'b0, wb_valid}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 reset req", {31'b0, mem_req}, 0);
    chk("R8 reset wb", {31'b0, wb_valid}, 0);
    chk("R6 reset fault", {31'b0, fault}, 0);
    rst_n = 1;
    for (int s = 1; s <= 4; s++)
      for (int o = 0; o < 4; o++)
        run_op(0, s, 32'h1000 + o, 16'h0000, 1);
    for (int o = 0; o < 4; o++) run_op(1, 6, 32'h2000, 16'(o), 0);
    run_op(1, 7, 32'h3000, 16'h0002, 2);
    run_op(1, 5, 32'h0001_0000, 16'hF804, 1);
    run_op(0, 0, 32'h0000_0010, 16'hFFF0, 0);
    run_op(0, 0, 32'h0000_0012, 16'h0000, 0);
    run_op(1, 7, 32'h0000_0011, 16'h0000, 0);
    run_op(2, 0, 32'h0, 16'h0, 0);
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 2);
      int s = (k == 0) ? $urandom_range(0, 4) : $urandom_range(5, 7);
      run_op(k, s, $urandom, 16'($urandom), $urandom_range(0, 3));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule